// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It moves byte items between a memory region and a peripheral data register through a simple single-cycle bus master port. Software sets the channel up through a small register window. That window holds a control word, a peripheral address, a memory address and an item count. Setting the enable bit starts the transfer.

Each item takes two bus cycles: a read at the source pointer, then a write of that byte to the destination pointer. The channel can pace items in two ways. In request-paced mode it waits for the peripheral's level request and answers each item with a one-cycle acknowledge. In memory-to-memory mode it ignores the request and issues items back to back, whether or not the target can accept them. When the count runs out, a completion flag is raised. Software clears that flag through a write-one-to-clear register.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, every register reads 0, `bus_valid`, `per_ack` and `tc_flag` are 0, and the channel is disabled.
- R2: While control bit 0 reads 1, writes to the peripheral address (index 1), the memory address (index 2) and the count (index 3) are ignored. A control write (index 0) then changes only bit 0.
- R3: When control bit 14 is 0, the channel moves one item per sampled request:
  - The request is sampled only while the channel is waiting.
  - The read cycle (`bus_valid`=1, `bus_write`=0) follows a cycle with `per_req` high, and the write cycle follows on the next clock.
  - `per_ack` is high for exactly the one cycle after the write.
  - The request is not sampled in the cycle after the acknowledge.
- R4: When control bit 14 is 1, `per_req` is ignored and `per_ack` stays 0. Items issue every 3 cycles (wait, read, write), so a slow target loses bytes.
- R5: Control bit 4 sets the direction. A value of 1 reads at the memory pointer and writes to the peripheral pointer; a value of 0 does the reverse.
- R6: Control bit 7 makes the memory pointer advance by 1 per item, and bit 6 does the same for the peripheral pointer. A pointer whose bit is 0 stays fixed for the whole block.
- R7: The count register (index 3) drops by 1 per item. When it reaches 0, the status register (index 4) bit 0 and `tc_flag` are set, and a non-circular channel issues no further bus cycles, although bit 0 still reads 1.
- R8: With control bit 5 set, finishing the last item reloads the programmed count and returns both pointers to their programmed start addresses. The transfer then continues.
- R9: Writing 1 to bit 0 of the flag-clear register (index 5) clears the completion flag. Writing 0 leaves it unchanged.
- R10: After software writes 0 to control bit 0, the item in progress completes and no further bus cycles are issued. From that point, bit 0 reads 0 once the channel is idle, and while it reads 0, `bus_valid` stays 0.
- R11: The element-size fields (bits 9:8 and 11:10) and the priority field (bits 13:12) read back as written. Only size 00, bytes, is moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 peripheral address, 2 memory address, 3 count, 4 status, 5 flag clear) |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Read data for `reg_addr` (combinational) |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| per_req | input | 1 | Peripheral request level |
| per_ack | output | 1 | One-cycle acknowledge after each paced item |
| tc_flag | output | 1 | Completion flag |

## Verification
The bench builds the channel with its default 16-bit address, count and register widths. It attaches a 256-byte memory model and a peripheral register at address 0x0100 that refuses writes for 8 cycles after each accepted byte. These values make a 3-cycle memory-to-memory item clearly outrun the target, so byte loss is visible. The same widths leave room to run paced, circular and disable-mid-block traffic over both pointer increment settings.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic [2:0] {
      ST_WAIT,
      ST_READ,
      ST_WRITE,
      ST_ACK,
      ST_GAP
   } seq_state_t;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_PADDR = 3'd1;
   localparam logic [2:0] RA_MADDR = 3'd2;
   localparam logic [2:0] RA_COUNT = 3'd3;
   localparam logic [2:0] RA_STAT  = 3'd4;
   localparam logic [2:0] RA_FCLR  = 3'd5;

   localparam int B_EN   = 0;
   localparam int B_DIR  = 4;
   localparam int B_CIRC = 5;
   localparam int B_PINC = 6;
   localparam int B_MINC = 7;
   localparam int B_PSZ  = 8;
   localparam int B_MSZ  = 10;
   localparam int B_PRIO = 12;
   localparam int B_M2M  = 14;

   typedef struct packed {
      logic       dir;
      logic       circ;
      logic       pinc;
      logic       minc;
      logic       m2m;
      logic [1:0] psz;
      logic [1:0] msz;
      logic [1:0] prio;
   } chan_cfg_t;
endpackage

// File: rtl/dma_chan_ptr.sv
module dma_chan_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= base;
      else if (step) ptr <= ptr + AW'(1);
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [2:0]    addr,
   input  logic [RW-1:0] wdata,
   output logic [RW-1:0] rdata,
   input  logic          active,
   input  logic          item_done,
   output logic          en_cfg,
   output logic          lock,
   output logic          start,
   output logic          wrap,
   output logic          cnt_nz,
   output chan_cfg_t     cfg,
   output logic [AW-1:0] pa_start,
   output logic [AW-1:0] ma_start,
   output logic          tc
);
   logic [CW-1:0] cnt_q, cnt_init;
   logic          unused_bits;

   assign unused_bits = ^{wdata[3:1], wdata[RW-1:15]};
   assign lock   = en_cfg | active;
   assign start  = wr && (addr == RA_CTRL) && !lock && wdata[B_EN];
   assign wrap   = cfg.circ && (cnt_q == CW'(1));
   assign cnt_nz = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_cfg   <= 1'b0;
         cfg      <= '0;
         pa_start <= '0;
         ma_start <= '0;
         cnt_q    <= '0;
         cnt_init <= '0;
         tc       <= 1'b0;
      end else begin
         if (wr) begin
            unique case (addr)
               RA_CTRL: begin
                  en_cfg <= wdata[B_EN];
                  if (!lock) begin
                     cfg.dir  <= wdata[B_DIR];
                     cfg.circ <= wdata[B_CIRC];
                     cfg.pinc <= wdata[B_PINC];
                     cfg.minc <= wdata[B_MINC];
                     cfg.m2m  <= wdata[B_M2M];
                     cfg.psz  <= wdata[B_PSZ+:2];
                     cfg.msz  <= wdata[B_MSZ+:2];
                     cfg.prio <= wdata[B_PRIO+:2];
                  end
               end
               RA_PADDR: if (!lock) pa_start <= wdata[AW-1:0];
               RA_MADDR: if (!lock) ma_start <= wdata[AW-1:0];
               RA_COUNT: if (!lock) begin
                  cnt_q    <= wdata[CW-1:0];
                  cnt_init <= wdata[CW-1:0];
               end
               RA_FCLR:  if (wdata[0]) tc <= 1'b0;
               default: ;
            endcase
         end
         if (item_done) begin
            if (cnt_q == CW'(1)) begin
               tc    <= 1'b1;
               cnt_q <= cfg.circ ? cnt_init : '0;
            end else begin
               cnt_q <= cnt_q - CW'(1);
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         RA_CTRL: begin
            rdata[B_EN]     = lock;
            rdata[B_DIR]    = cfg.dir;
            rdata[B_CIRC]   = cfg.circ;
            rdata[B_PINC]   = cfg.pinc;
            rdata[B_MINC]   = cfg.minc;
            rdata[B_M2M]    = cfg.m2m;
            rdata[B_PSZ+:2] = cfg.psz;
            rdata[B_MSZ+:2] = cfg.msz;
            rdata[B_PRIO+:2] = cfg.prio;
         end
         RA_PADDR: rdata[AW-1:0] = pa_start;
         RA_MADDR: rdata[AW-1:0] = ma_start;
         RA_COUNT: rdata[CW-1:0] = cnt_q;
         RA_STAT:  rdata[0]      = tc;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_chan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_cfg,
   input  logic       cnt_nz,
   input  logic       m2m,
   input  logic       per_req,
   input  logic [7:0] rd_byte,
   output logic [7:0] wr_byte,
   output logic       bus_valid,
   output logic       bus_write,
   output logic       rd_phase,
   output logic       item_done,
   output logic       per_ack,
   output logic       active
);
   seq_state_t state, nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_WAIT:  if (en_cfg && cnt_nz && (m2m || per_req)) nxt = ST_READ;
         ST_READ:  nxt = ST_WRITE;
         ST_WRITE: nxt = m2m ? ST_WAIT : ST_ACK;
         ST_ACK:   nxt = ST_GAP;
         ST_GAP:   nxt = ST_WAIT;
         default:  nxt = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_WAIT;
         wr_byte <= '0;
      end else begin
         state <= nxt;
         if (state == ST_READ) wr_byte <= rd_byte;
      end
   end

   assign rd_phase  = (state == ST_READ);
   assign bus_write = (state == ST_WRITE);
   assign bus_valid = rd_phase | bus_write;
   assign item_done = bus_write;
   assign per_ack   = (state == ST_ACK);
   assign active    = (state != ST_WAIT);
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
   import dma_chan_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          bus_valid,
   output logic          bus_write,
   output logic [AW-1:0] bus_addr,
   output logic [7:0]    bus_wdata,
   input  logic [7:0]    bus_rdata,
   input  logic          per_req,
   output logic          per_ack,
   output logic          tc_flag
);
   localparam int NPTR = 2;

   generate
      if (RW < 16) begin : g_rw_chk
         $error("RW must hold the 15 control bits");
      end
      if (AW > RW || CW > RW) begin : g_fit_chk
         $error("AW and CW must fit in RW");
      end
      if (AW < 2 || CW < 2) begin : g_min_chk
         $error("AW and CW must be at least 2");
      end
   endgenerate

   chan_cfg_t     cfg;
   logic          en_cfg, lock, start, wrap, cnt_nz, active, item_done, rd_phase;
   logic [AW-1:0] pa_start, ma_start;
   logic          m2m_mode, en_rb;
   logic [AW-1:0] base_a [NPTR];
   logic          inc_a  [NPTR];
   logic [AW-1:0] ptr_a  [NPTR];
   logic [AW-1:0] src_ptr, dst_ptr;

   assign m2m_mode = cfg.m2m;
   assign en_rb    = lock;

   dma_chan_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .active(active), .item_done(item_done), .en_cfg(en_cfg),
      .lock(lock), .start(start), .wrap(wrap), .cnt_nz(cnt_nz), .cfg(cfg),
      .pa_start(pa_start), .ma_start(ma_start), .tc(tc_flag)
   );

   dma_chan_seq u_seq (
      .clk(clk), .rst_n(rst_n), .en_cfg(en_cfg), .cnt_nz(cnt_nz), .m2m(cfg.m2m),
      .per_req(per_req), .rd_byte(bus_rdata), .wr_byte(bus_wdata),
      .bus_valid(bus_valid), .bus_write(bus_write), .rd_phase(rd_phase),
      .item_done(item_done), .per_ack(per_ack), .active(active)
   );

   assign base_a[0] = pa_start;
   assign base_a[1] = ma_start;
   assign inc_a[0]  = cfg.pinc;
   assign inc_a[1]  = cfg.minc;

   generate
      for (genvar g = 0; g < NPTR; g++) begin : g_ptr
         dma_chan_ptr #(.AW(AW)) u_ptr (
            .clk(clk), .rst_n(rst_n),
            .load(start | (item_done & wrap)),
            .step(item_done & inc_a[g]),
            .base(base_a[g]),
            .ptr(ptr_a[g])
         );
      end
   endgenerate

   assign src_ptr  = cfg.dir ? ptr_a[1] : ptr_a[0];
   assign dst_ptr  = cfg.dir ? ptr_a[0] : ptr_a[1];
   assign bus_addr = rd_phase ? src_ptr : dst_ptr;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_valid,
   input logic          bus_write,
   input logic          per_req,
   input logic          per_ack,
   input logic          m2m_mode,
   input logic          lock,
   input logic          en_rb,
   input logic          tc_flag,
   input logic [AW-1:0] pa_start,
   input logic [AW-1:0] ma_start
);
   // R3
   ack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_ack |-> $past(bus_valid && bus_write));

   // R3
   paced_read_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && !m2m_mode) |-> $past(per_req));

   // R3
   write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write) |-> $past(bus_valid && !bus_write));

   // R4
   no_ack_in_m2m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m2m_mode |-> !per_ack);

   // R2
   paddr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock) |-> $stable(pa_start));

   // R2
   maddr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock) |-> $stable(ma_start));

   // R7
   flag_set_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_flag) |-> $past(bus_valid && bus_write));

   // R10
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_rb |-> !bus_valid);
endmodule

bind dma_chan_top dma_chan_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .per_req(per_req), .per_ack(per_ack), .m2m_mode(m2m_mode), .lock(lock),
   .en_rb(en_rb), .tc_flag(tc_flag), .pa_start(pa_start), .ma_start(ma_start)
);

// File: tb/sim_dma_chan_top.sv
`timescale 1ns/1ps
module sim_dma_chan_top;
   localparam int AW = 16;
   localparam int CW = 16;
   localparam int RW = 16;
   localparam logic [AW-1:0] PER_ADDR = 16'h0100;
   localparam int BUSY = 8;

   localparam logic [15:0] C_EN = 16'h0001, C_DIR = 16'h0010, C_CIRC = 16'h0020,
                           C_PINC = 16'h0040, C_MINC = 16'h0080, C_M2M = 16'h4000;

   logic          clk = 0, rst_n = 0;
   logic          reg_wr = 0;
   logic [2:0]    reg_addr = 0;
   logic [RW-1:0] reg_wdata = 0, reg_rdata;
   logic          bus_valid, bus_write, per_ack, tc_flag, per_req;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata, bus_rdata;

   int tests = 0, fails = 0;
   int cyc = 0;
   logic [7:0] mem [256];
   logic [7:0] rxq [$];
   int   drops = 0;
   logic p_ready = 1;
   int   p_busy = 0;
   logic hold = 1;
   logic m2m_tb = 0;
   logic [AW+7:0] expq [$];
   int   nwrites = 0;
   int   last_wr = -1;
   logic prev_wr = 0;

   always #2.5 clk = ~clk;

   dma_chan_top #(.AW(AW), .CW(CW), .RW(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .per_req(per_req), .per_ack(per_ack), .tc_flag(tc_flag)
   );

   assign bus_rdata = (bus_addr < 16'd256) ? mem[bus_addr[7:0]] : 8'h00;
   assign per_req   = p_ready && !hold;

   // memory and slow peripheral that drops writes while busy
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && bus_valid && bus_write) begin
         if (bus_addr < 16'd256) mem[bus_addr[7:0]] <= bus_wdata;
         if (bus_addr == PER_ADDR) begin
            if (p_ready) begin
               rxq.push_back(bus_wdata);
               p_ready <= 1'b0;
               p_busy  <= BUSY;
            end else drops++;
         end
      end else if (!p_ready) begin
         if (p_busy <= 1) p_ready <= 1'b1;
         else p_busy <= p_busy - 1;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (per_ack || (prev_wr && !m2m_tb))
            chk(per_ack == (prev_wr && !m2m_tb), "R3 ack timing", per_ack, prev_wr && !m2m_tb);
         if (bus_valid && bus_write) begin
            if (expq.size() == 0) chk(1'b0, "R7 unexpected write", bus_addr, 0);
            else begin
               logic [AW+7:0] e;
               e = expq.pop_front();
               chk({bus_addr, bus_wdata} == e, "R5/R6 write addr/data", {bus_addr, bus_wdata}, e);
            end
            if (m2m_tb && last_wr >= 0) chk(cyc - last_wr == 3, "R4 item spacing", cyc - last_wr, 3);
            last_wr = cyc;
            nwrites++;
         end
         prev_wr = bus_valid && bus_write;
      end
   end

   always @(posedge clk) if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a;
      #0.5 v = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic stop_chan();
      logic [15:0] v;
      wr_reg(3'd0, 16'h0000);
      do rd_reg(3'd0, v); while (v[0]);
   endtask

   initial begin
      logic [15:0] v;
      int k;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      idle(3);
      rst_n = 1;
      idle(2);

      // R1 reset state
      for (int r = 0; r < 5; r++) begin
         rd_reg(3'(r), v);
         chk(v == 0, "R1 reset register", v, 0);
      end
      chk(!bus_valid && !per_ack && !tc_flag, "R1 reset outputs", {bus_valid, per_ack, tc_flag}, 0);

      // R2 / R3 / R7 / R11: paced memory -> peripheral, 6 items
      wr_reg(3'd1, PER_ADDR);
      wr_reg(3'd2, 16'h0010);
      wr_reg(3'd3, 16'd6);
      for (int i = 0; i < 6; i++) expq.push_back({PER_ADDR, mem[16 + i]});
      m2m_tb = 0; hold = 1;
      wr_reg(3'd0, C_EN | C_DIR | C_MINC | 16'h3A00);
      rd_reg(3'd0, v);
      chk(v == (C_EN | C_DIR | C_MINC | 16'h3A00), "R11 size/priority readback", v, C_EN | C_DIR | C_MINC | 16'h3A00);
      wr_reg(3'd1, 16'h0055);
      wr_reg(3'd3, 16'd3);
      wr_reg(3'd0, C_EN | C_M2M | C_CIRC);
      rd_reg(3'd1, v); chk(v == PER_ADDR, "R2 paddr locked", v, PER_ADDR);
      rd_reg(3'd3, v); chk(v == 6, "R2 count locked", v, 6);
      rd_reg(3'd0, v); chk(v == (C_EN | C_DIR | C_MINC | 16'h3A00), "R2 ctrl locked", v, C_EN | C_DIR | C_MINC | 16'h3A00);
      chk(nwrites == 0, "R3 no item without request", nwrites, 0);
      hold = 0;
      do rd_reg(3'd4, v); while (!v[0]);
      idle(30);
      chk(rxq.size() == 6 && drops == 0, "R3 paced delivers all", rxq.size() * 256 + drops, 6 * 256);
      for (int i = 0; i < 6 && i < rxq.size(); i++) chk(rxq[i] == mem[16 + i], "R3 byte order", rxq[i], mem[16 + i]);
      rd_reg(3'd3, v); chk(v == 0, "R7 count zero", v, 0);
      chk(tc_flag == 1, "R7 flag set", tc_flag, 1);
      rd_reg(3'd0, v); chk(v[0] == 1, "R7 enable stays", v[0], 1);
      chk(expq.size() == 0, "R7 stops at zero", expq.size(), 0);

      // R9 flag clear
      wr_reg(3'd5, 16'h0000);
      rd_reg(3'd4, v); chk(v[0] == 1, "R9 zero write no effect", v[0], 1);
      wr_reg(3'd5, 16'h0001);
      rd_reg(3'd4, v); chk(v[0] == 0, "R9 write one clears", v[0], 0);

      // R4 memory-to-memory ignores requests and overruns target
      stop_chan();
      rxq.delete(); drops = 0; hold = 1;
      idle(12);
      wr_reg(3'd2, 16'h0020);
      wr_reg(3'd3, 16'd8);
      for (int i = 0; i < 8; i++) expq.push_back({PER_ADDR, mem[32 + i]});
      m2m_tb = 1; last_wr = -1;
      wr_reg(3'd0, C_EN | C_DIR | C_MINC | C_M2M);
      idle(40);
      chk(expq.size() == 0, "R4 all items issued without request", expq.size(), 0);
      chk(rxq.size() < 8 && drops > 0, "R4 target loses bytes", rxq.size(), 8);
      chk(rxq.size() + drops == 8, "R4 write total", rxq.size() + drops, 8);

      // R5 / R6 peripheral->memory, both pointers increment
      stop_chan();
      for (int i = 0; i < 4; i++) mem[64 + i] = 8'hA0 + 8'(i);
      wr_reg(3'd1, 16'h0040);
      wr_reg(3'd2, 16'h0080);
      wr_reg(3'd3, 16'd4);
      for (int i = 0; i < 4; i++) expq.push_back({16'h0080 + 16'(i), 8'hA0 + 8'(i)});
      last_wr = -1;
      wr_reg(3'd0, C_EN | C_PINC | C_MINC | C_M2M);
      idle(20);
      chk(expq.size() == 0, "R5 reverse direction done", expq.size(), 0);
      chk(mem[130] == 8'hA2, "R5 memory destination", mem[130], 8'hA2);

      // R6 fixed memory source, incrementing peripheral pointer
      stop_chan();
      wr_reg(3'd1, 16'h00A0);
      wr_reg(3'd2, 16'h0030);
      wr_reg(3'd3, 16'd3);
      for (int i = 0; i < 3; i++) expq.push_back({16'h00A0 + 16'(i), mem[48]});
      last_wr = -1;
      wr_reg(3'd0, C_EN | C_DIR | C_PINC | C_M2M);
      idle(16);
      chk(expq.size() == 0, "R6 fixed source", expq.size(), 0);

      // R8 circular paced
      stop_chan();
      wr_reg(3'd5, 16'h0001);
      rxq.delete(); drops = 0; m2m_tb = 0; hold = 1;
      idle(12);
      wr_reg(3'd1, PER_ADDR);
      wr_reg(3'd2, 16'h0010);
      wr_reg(3'd3, 16'd3);
      for (int i = 0; i < 7; i++) expq.push_back({PER_ADDR, mem[16 + (i % 3)]});
      wr_reg(3'd0, C_EN | C_DIR | C_MINC | C_CIRC);
      hold = 0;
      while (rxq.size() < 7) @(negedge clk);
      hold = 1;
      idle(6);
      stop_chan();
      chk(expq.size() == 0, "R8 wrap sequence", expq.size(), 0);
      rd_reg(3'd3, v); chk(v == 2, "R8 count reload", v, 2);
      chk(tc_flag == 1, "R8 flag on wrap", tc_flag, 1);

      // R10 disable mid-block
      for (int i = 0; i < 10; i++) expq.push_back({PER_ADDR, mem[48 + i]});
      wr_reg(3'd2, 16'h0030);
      wr_reg(3'd3, 16'd10);
      m2m_tb = 1; last_wr = -1;
      wr_reg(3'd0, C_EN | C_DIR | C_MINC | C_M2M);
      idle(7);
      wr_reg(3'd0, 16'h0000);
      k = 0;
      do begin rd_reg(3'd0, v); k++; end while (v[0] && k < 10);
      chk(v[0] == 0 && k <= 3, "R10 enable reads 0 once idle", k, 3);
      k = nwrites;
      idle(12);
      chk(nwrites == k, "R10 no cycles after stop", nwrites, k);
      rd_reg(3'd3, v);
      chk(v == expq.size(), "R10 count matches issued", v, expq.size());
      expq.delete();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule